// File: doc/BRIEF.md
# Dual-Mode Byte Serial Port (SPI Master/Slave)

The block is a byte-wide SPI port that runs either as the bus master, generating the serial clock itself, or as a bus slave that follows an external clock. A 4-bit mode field in a small control register picks the role. An enable bit in the same register gates the whole port. When software clears that bit, the shift logic, the bit counter and all status flags return to their idle values. Software then rewrites the mode, polarity and rate fields and sets the enable bit again.

Each transfer is full duplex. One 8-bit shift register sends its contents out most-significant bit first and collects the incoming bits in the same register. When the eighth bit has arrived, the received byte goes to a receive buffer and a buffer-full flag is raised. Writing the data port loads the shift register. In master mode that write also starts the transfer. In slave mode it prepares the byte that the remote master will clock out. A write-collision flag and an overflow flag report misuse. Both stay set until the port is disabled.

Top module: `spi_port`

## Requirements
- R1: While the enable bit (control bit 5) is clear, the port is inert. `busy` stays 0, `sdoOe` is 0 and `sckOut` rests at the polarity level. Data writes start nothing. Clearing the enable bit during a transfer ends it within two clocks and clears `bufFull`, `overflow` and `wrCollision`.
- R2: With the port enabled, mode field (control bits 3:0) values 00xx select master and 010x select slave. Any other value leaves the port inactive: a data write does not set `busy` and `sdoOe` stays 0.
- R3: In master mode, a data write while not busy starts a transfer of 8 SCK cycles. The SCK period in system clocks is 4, 16 or 64 for rate bits (control bits 1:0) 00, 01 or 1x.
- R4: Control bit 4 sets the idle level of SCK. In master mode `sckOut` equals that bit whenever no transfer runs, and the slave treats a move away from that level as the leading edge.
- R5: Data leaves MSB first. `sdo` changes only on the trailing (back-to-idle) SCK edge, and the input bit is sampled on the leading edge, so one byte goes out while one comes in.
- R6: After the eighth trailing edge, the received byte appears on `bufData` and `bufFull` is set. A `bufRd` pulse clears `bufFull`.
- R7: If a byte completes while `bufFull` is set, `overflow` is raised and `bufData` keeps its previous value. `overflow` stays set until the port is disabled.
- R8: A data write while `busy` is high sets `wrCollision` and leaves the byte being shifted unchanged.
- R9: In slave mode 0100, a high `ssN` sets `sdoOe` to 0 and resets the bit counter, so a partial byte is discarded and `busy` drops. In mode 0101, `ssN` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWr | input | 1 | Write strobe for the control register |
| ctrlData | input | 6 | Control value: [5] enable, [4] clock polarity, [3:0] mode/rate |
| bufWr | input | 1 | Data write strobe: loads the shift register |
| bufWrData | input | 8 | Byte to transmit |
| bufRd | input | 1 | Data read strobe: clears the buffer-full flag |
| bufData | output | 8 | Last received byte |
| busy | output | 1 | A transfer is in progress |
| bufFull | output | 1 | A received byte is waiting to be read |
| overflow | output | 1 | A byte was lost because the buffer was full |
| wrCollision | output | 1 | A data write arrived during a transfer |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckIn | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for sdo (0 means high impedance) |
| sdi | input | 1 | Serial data in |
| ssN | input | 1 | Slave select, active low |

## Verification
The bench measures the master SCK period at all three rates and checks the idle level under both polarities. A divider that is off by one, or an inverted polarity, shows up as a wrong period or a wrong resting level. It sends a second byte into a full buffer. A design that overwrote the buffer would show the new byte instead of the old one and no overflow. It writes the data port in the middle of a transfer, where a faulty design would corrupt the outgoing bits or miss the collision flag. It also drops slave-select partway through a slave byte. If the bit counter were not reset, the following byte would complete early and land misaligned in the buffer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int CTRL_W  = 6;
  localparam int EN_BIT  = 5;
  localparam int POL_BIT = 4;

  typedef struct packed {
    logic load;     // copy the write byte into the shift register
    logic sample;   // capture the input bit (leading edge)
    logic shift;    // advance the shift register (trailing edge)
    logic done;     // last bit of the byte shifted in
    logic collide;  // write arrived while busy
    logic flush;    // port disabled: clear flags
    logic rd;       // buffer read
    logic sdiBit;   // input bit to capture
  } strobe_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 4,
  parameter int DIV1   = 16,
  parameter int DIV2   = 64,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              bufWr,
  input  logic              bufRd,
  input  logic              sckIn,
  input  logic              sdi,
  input  logic              ssN,
  output strobe_t           stb,
  output logic              busy,
  output logic              sckOut,
  output logic              sdoOe
);
  localparam int CNT_W = (DIV2 / 2 > 1) ? $clog2(DIV2 / 2) : 1;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF0 = CNT_W'(DIV0 / 2 - 1);
  localparam logic [CNT_W-1:0] HALF1 = CNT_W'(DIV1 / 2 - 1);
  localparam logic [CNT_W-1:0] HALF2 = CNT_W'(DIV2 / 2 - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  divCnt, halfLim;
  logic [BIT_W-1:0]  bitCnt;
  logic              phase, xferOn;
  logic [SYNC_W-1:0] sckS, ssS, sdiS;
  logic              sckPrev;

  logic enable, pol, isMaster, isSlave, ssUse, slaveGo;
  logic tick, mLead, mTrail, sLevel, sPrevLevel, sLead, sTrail;
  logic lead, trail, lastBit, active;

  assign enable   = ctrlReg[EN_BIT];
  assign pol      = ctrlReg[POL_BIT];
  assign isMaster = enable && (ctrlReg[3:2] == 2'b00);
  assign isSlave  = enable && (ctrlReg[3:1] == 3'b010);
  assign ssUse    = !ctrlReg[0];
  assign slaveGo  = isSlave && !(ssUse && ssS[SYNC_W-1]);
  assign active   = isMaster || isSlave;

  always_comb begin
    unique case (ctrlReg[1:0])
      2'b00:   halfLim = HALF0;
      2'b01:   halfLim = HALF1;
      default: halfLim = HALF2;
    endcase
  end

  assign tick       = xferOn && (divCnt == halfLim);
  assign mLead      = tick && !phase;
  assign mTrail     = tick && phase;
  assign sLevel     = sckS[SYNC_W-1] ^ pol;
  assign sPrevLevel = sckPrev ^ pol;
  assign sLead      = slaveGo && sLevel && !sPrevLevel;
  assign sTrail     = slaveGo && !sLevel && sPrevLevel;
  assign lead       = mLead || sLead;
  assign trail      = mTrail || sTrail;
  assign lastBit    = trail && (bitCnt == LAST_BIT);

  assign busy   = isMaster ? xferOn : (slaveGo && ((bitCnt != '0) || sLevel));
  assign sckOut = pol ^ phase;
  assign sdoOe  = isMaster || slaveGo;

  always_comb begin
    stb         = '0;
    stb.load    = bufWr && active && !busy;
    stb.collide = bufWr && active && busy;
    stb.sample  = lead;
    stb.shift   = trail;
    stb.done    = lastBit;
    stb.flush   = !enable;
    stb.rd      = bufRd;
    stb.sdiBit  = isMaster ? sdi : sdiS[SYNC_W-1];
  end

  // control register and input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      sckS    <= '0;
      sckPrev <= 1'b0;
      ssS     <= '1;
      sdiS    <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= ctrlData;
      sckS    <= {sckS[SYNC_W-2:0], sckIn};
      sckPrev <= sckS[SYNC_W-1];
      ssS     <= {ssS[SYNC_W-2:0], ssN};
      sdiS    <= {sdiS[SYNC_W-2:0], sdi};
    end
  end

  // master clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferOn <= 1'b0;
      phase  <= 1'b0;
      divCnt <= '0;
    end else if (!isMaster) begin
      xferOn <= 1'b0;
      phase  <= 1'b0;
      divCnt <= '0;
    end else if (stb.load) begin
      xferOn <= 1'b1;
      phase  <= 1'b0;
      divCnt <= '0;
    end else if (xferOn) begin
      if (tick) begin
        divCnt <= '0;
        phase  <= !phase;
        if (lastBit) xferOn <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // bit counter shared by both roles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!(isMaster || slaveGo)) begin
      bitCnt <= '0;
    end else if (trail) begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] bufWrData,
  output logic              sdo,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              overflow,
  output logic              wrCollision
);
  logic [DATA_W-1:0] shiftReg, nextByte;
  logic              sampled;

  assign nextByte = {shiftReg[DATA_W-2:0], sampled};
  assign sdo      = shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sampled  <= 1'b0;
    end else begin
      if (stb.load)        shiftReg <= bufWrData;
      else if (stb.shift)  shiftReg <= nextByte;
      if (stb.sample)      sampled  <= stb.sdiBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData     <= '0;
      bufFull     <= 1'b0;
      overflow    <= 1'b0;
      wrCollision <= 1'b0;
    end else if (stb.flush) begin
      bufFull     <= 1'b0;
      overflow    <= 1'b0;
      wrCollision <= 1'b0;
    end else begin
      if (stb.collide) wrCollision <= 1'b1;
      if (stb.done) begin
        if (bufFull && !stb.rd) begin
          overflow <= 1'b1;
        end else begin
          bufData <= nextByte;
          bufFull <= 1'b1;
        end
      end else if (stb.rd) begin
        bufFull <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 4,
  parameter int DIV1   = 16,
  parameter int DIV2   = 64,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRd,
  output logic [DATA_W-1:0] bufData,
  output logic              busy,
  output logic              bufFull,
  output logic              overflow,
  output logic              wrCollision,
  output logic              sckOut,
  input  logic              sckIn,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              sdi,
  input  logic              ssN
);
  strobe_t stb;

  spi_port_ctrl #(
    .DATA_W(DATA_W), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .SYNC_W(SYNC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .bufWr(bufWr), .bufRd(bufRd), .sckIn(sckIn), .sdi(sdi), .ssN(ssN),
    .stb(stb), .busy(busy), .sckOut(sckOut), .sdoOe(sdoOe)
  );

  spi_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bufWrData(bufWrData),
    .sdo(sdo), .bufData(bufData), .bufFull(bufFull),
    .overflow(overflow), .wrCollision(wrCollision)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWr,
  input logic [5:0]        ctrlData,
  input logic              bufWr,
  input logic              bufRd,
  input logic [DATA_W-1:0] bufData,
  input logic              busy,
  input logic              bufFull,
  input logic              overflow,
  input logic              wrCollision,
  input logic              sckOut,
  input logic              sdoOe,
  input logic              ssN
);
  logic [5:0] shadow;
  logic enSh, polSh, masterSh, slaveSsSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       shadow <= '0;
    else if (ctrlWr) shadow <= ctrlData;
  end

  assign enSh      = shadow[5];
  assign polSh     = shadow[4];
  assign masterSh  = enSh && (shadow[3:2] == 2'b00);
  assign slaveSsSh = enSh && (shadow[3:0] == 4'b0100);

  // R1
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!enSh && $past(!enSh)) |-> (!busy && !sdoOe && !bufFull && !overflow && !wrCollision));
  // R3
  a_r3_write_starts: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && !busy && masterSh) |=> busy);
  // R4
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (masterSh && !busy) |-> (sckOut == polSh));
  // R7
  a_r7_buf_held: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !bufRd) |=> $stable(bufData));
  // R7
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && enSh && !(ctrlWr && !ctrlData[5])) |=> overflow);
  // R8
  a_r8_collision: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && busy && enSh) |=> wrCollision);
  // R9
  a_r9_ss_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (slaveSsSh && $past(slaveSsSh) && ssN && $past(ssN) && $past(ssN, 2) && $past(ssN, 3))
      |-> !sdoOe);
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
  .bufWr(bufWr), .bufRd(bufRd), .bufData(bufData), .busy(busy),
  .bufFull(bufFull), .overflow(overflow), .wrCollision(wrCollision),
  .sckOut(sckOut), .sdoOe(sdoOe), .ssN(ssN)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [5:0] ctrlData = '0;
  logic       bufWr = 1'b0;
  logic [7:0] bufWrData = '0;
  logic       bufRd = 1'b0;
  logic [7:0] bufData;
  logic       busy, bufFull, overflow, wrCollision, sckOut, sdo, sdoOe;
  logic       sckIn = 1'b0;
  logic       sdi = 1'b0;
  logic       ssN = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .bufWr(bufWr), .bufWrData(bufWrData), .bufRd(bufRd), .bufData(bufData),
    .busy(busy), .bufFull(bufFull), .overflow(overflow), .wrCollision(wrCollision),
    .sckOut(sckOut), .sckIn(sckIn), .sdo(sdo), .sdoOe(sdoOe), .sdi(sdi), .ssN(ssN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [5:0] v);
    @(negedge clk); ctrlWr = 1'b1; ctrlData = v;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  // disable, then enable with new fields
  task automatic reconfig(input logic [5:0] v);
    write_ctrl(v & 6'h1F);
    write_ctrl(v);
    cycles(2);
  endtask

  task automatic write_buf(input logic [7:0] v);
    @(negedge clk); bufWr = 1'b1; bufWrData = v;
    @(negedge clk); bufWr = 1'b0;
  endtask

  task automatic read_buf();
    @(negedge clk); bufRd = 1'b1;
    @(negedge clk); bufRd = 1'b0;
  endtask

  // master transfer with a bench-side slave model
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] slv, input logic pol,
                             input bit doCollide, output logic [7:0] seen, output int period);
    logic [7:0] got = '0;
    int         per = 0;
    sdi = slv[7];
    fork
      begin
        realtime t0 = 0;
        for (int i = 0; i < 8; i++) begin
          wait (sckOut != pol);
          if (i == 0) t0 = $realtime;
          if (i == 1) per = int'(($realtime - t0) / 20.0);
          got[7-i] = sdo;
          wait (sckOut == pol);
          if (i < 7) sdi = slv[6-i];
        end
      end
      begin
        write_buf(tx);
        if (doCollide) begin
          cycles(6);
          write_buf(8'hFF);
        end
      end
    join
    wait (!busy);
    cycles(2);
    seen = got;
    period = per;
  endtask

  // bench acts as master towards a slave-mode port (polarity 0)
  task automatic slave_bits(input logic [7:0] rx, input int nBits, output logic [7:0] seen);
    logic [7:0] got = '0;
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk); sdi = rx[7-i];
      cycles(8);
      got[7-i] = sdo;
      sckIn = 1'b1;
      cycles(8);
      sckIn = 1'b0;
    end
    cycles(8);
    seen = got;
  endtask

  task automatic t_reset();
    chk(!busy && !bufFull && !overflow && !wrCollision, "R1 reset flags",
        {busy, bufFull, overflow, wrCollision}, 0);
    chk(!sdoOe && !sckOut, "R1 reset pins", {sdoOe, sckOut}, 0);
  endtask

  task automatic t_disabled();
    write_ctrl(6'h00);
    write_buf(8'hA5);
    cycles(20);
    chk(!busy && !sckOut && !sdoOe, "R1 disabled write ignored", {busy, sckOut, sdoOe}, 0);
    chk(!bufFull && !wrCollision, "R1 disabled no flags", {bufFull, wrCollision}, 0);
  endtask

  task automatic t_inactive_mode();
    reconfig(6'h26);
    write_buf(8'h11);
    cycles(4);
    chk(!busy && !sdoOe, "R2 mode 0110 inactive", {busy, sdoOe}, 0);
    chk(sckOut == 1'b0, "R2 no clock in inactive mode", sckOut, 0);
  endtask

  task automatic t_master(input logic [5:0] cfg, input logic [7:0] tx, input logic [7:0] slv,
                          input int expPer, input bit doRead);
    logic [7:0] seen;
    int         per;
    reconfig(cfg);
    chk(sckOut == cfg[4], "R4 idle level before", sckOut, cfg[4]);
    chk(sdoOe, "R2 master mode drives sdo", sdoOe, 1);
    master_xfer(tx, slv, cfg[4], 1'b0, seen, per);
    chk(per == expPer, "R3 SCK period", per, expPer);
    chk(seen == tx, "R5 bits out MSB first", seen, tx);
    chk(bufData == slv && bufFull, "R6 received byte", bufData, slv);
    chk(sckOut == cfg[4] && !busy, "R4 idle level after", sckOut, cfg[4]);
    if (doRead) begin
      read_buf();
      chk(!bufFull, "R6 read clears full", bufFull, 0);
    end
  endtask

  task automatic t_overflow();
    logic [7:0] seen;
    int         per;
    // buffer still holds 0xC3 from the previous transfer
    master_xfer(8'h0F, 8'hF0, 1'b0, 1'b0, seen, per);
    chk(overflow, "R7 overflow raised", overflow, 1);
    chk(bufData == 8'hC3, "R7 buffer kept", bufData, 8'hC3);
    read_buf();
    chk(!bufFull && overflow, "R7 overflow sticky after read", {bufFull, overflow}, 2'b01);
    write_ctrl(6'h02);
    cycles(2);
    chk(!overflow, "R1 disable clears overflow", overflow, 0);
  endtask

  task automatic t_collision();
    logic [7:0] seen;
    int         per;
    reconfig(6'h21);
    master_xfer(8'h96, 8'h69, 1'b0, 1'b1, seen, per);
    chk(wrCollision, "R8 collision flag", wrCollision, 1);
    chk(seen == 8'h96, "R8 shift register untouched", seen, 8'h96);
    chk(bufData == 8'h69, "R8 receive intact", bufData, 8'h69);
    read_buf();
  endtask

  task automatic t_disable_mid();
    reconfig(6'h22);
    write_buf(8'h55);
    cycles(40);
    chk(busy, "R3 transfer running", busy, 1);
    write_ctrl(6'h02);
    cycles(2);
    chk(!busy && !sckOut && !wrCollision, "R1 disable ends transfer",
        {busy, sckOut, wrCollision}, 0);
    chk(!sdoOe, "R1 disabled sdo released", sdoOe, 0);
  endtask

  task automatic t_slave_no_ss();
    logic [7:0] seen;
    ssN = 1'b1;
    reconfig(6'h25);
    chk(sdoOe, "R9 mode 0101 ignores ssN", sdoOe, 1);
    write_buf(8'h3A);
    slave_bits(8'hC5, 8, seen);
    chk(seen == 8'h3A, "R5 slave sends MSB first", seen, 8'h3A);
    chk(bufData == 8'hC5 && bufFull, "R6 slave receives", bufData, 8'hC5);
    read_buf();
  endtask

  task automatic t_slave_ss();
    logic [7:0] seen;
    ssN = 1'b1;
    reconfig(6'h24);
    cycles(4);
    chk(!sdoOe, "R9 ssN high releases sdo", sdoOe, 0);
    ssN = 1'b0;
    cycles(4);
    chk(sdoOe, "R9 ssN low drives sdo", sdoOe, 1);
    write_buf(8'hE7);
    slave_bits(8'hFF, 3, seen);
    chk(busy, "R9 partial byte in progress", busy, 1);
    ssN = 1'b1;
    cycles(6);
    chk(!busy && !bufFull, "R9 ssN high resets counter", {busy, bufFull}, 0);
    ssN = 1'b0;
    cycles(4);
    write_buf(8'h4B);
    slave_bits(8'h2D, 8, seen);
    chk(seen == 8'h4B, "R9 realigned transmit", seen, 8'h4B);
    chk(bufData == 8'h2D && bufFull, "R9 realigned receive", bufData, 8'h2D);
  endtask

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(2);
    t_reset();
    t_disabled();
    t_inactive_mode();
    t_master(6'h20, 8'hA5, 8'h3C, 4, 1'b1);
    t_master(6'h31, 8'h81, 8'h7E, 16, 1'b1);
    t_master(6'h22, 8'h5A, 8'hC3, 64, 1'b0);
    t_overflow();
    t_collision();
    t_disable_mid();
    t_slave_no_ss();
    t_slave_ss();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule